// File: doc/BRIEF.md
# Natural Logarithm Unit for Normalised Binary Floating Point

This block takes a positive value in the form m·2^e and returns its natural logarithm as a signed fixed-point number. The mantissa arrives as an unsigned 1.23 fixed-point word that must be normalised, with its integer bit set. The exponent arrives as an 8-bit two's-complement integer. A separate sign input marks negative operands.

The block splits the work in two. The exponent part is the product e·ln 2, and ln 2 is held as a rounded constant with 28 fractional bits. The mantissa part first forms x = m − 1. It then divides to get y = x/(2 + x). A rational function of y gives ln m ≈ 2y·(15 − 4y²)/(15 − 9y²), which is good to roughly five decimal digits over the whole mantissa range. Both divisions run one after the other on a single restoring divider inside the block, so every operation takes the same fixed number of cycles.

A caller raises `start` while `busy` is low. The result appears together with a one-cycle `done` pulse. Negative or unnormalised operands are not computed: they set `err` and return the most negative output code.

Top module: `lnq_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done` and `err` are 0 and `result` is 0.
- R2: `done` is a single-cycle pulse. It is seen exactly 50 clock edges after the edge at which `start` was accepted.
- R3: `start` is accepted only at an edge where `busy` is low. `busy` is high from the edge after acceptance up to, but not including, the `done` cycle. A `start` raised while `busy` is high is ignored and changes neither the timing nor the result of the running operation.
- R4: With exponent 0, the result is ln(m) to within 1e-4. The mantissa `in_mant` is read as unsigned with bit 23 as the integer bit and bits 22..0 as the fraction.
- R5: A nonzero exponent adds e·ln 2 to the mantissa term. `in_exp` is read as two's complement, and its extremes −128 and +127 are included. The 1e-4 tolerance still applies.
- R6: `result` is two's complement with 8 integer bits and 20 fractional bits, so one LSB is 2^-20.
- R7: An operand with `in_neg` = 1 completes with `err` = 1 and `result` = 0x8000000, the most negative code.
- R8: An operand whose mantissa bit 23 is 0 (zero included) completes with `err` = 1 and `result` = 0x8000000.
- R9: The operand m = 1.0 with e = 0 gives a result of exactly 0.
- R10: `result` and `err` change only in a `done` cycle, and they hold their values between completions. A valid operand that follows an error clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation (taken when busy is low) |
| in_neg | input | 1 | Operand sign; 1 marks a negative operand |
| in_mant | input | 24 | Mantissa, unsigned 1.23 fixed point |
| in_exp | input | 8 | Exponent, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed operand was negative or unnormalised |
| result | output | 28 | Natural log, signed 8.20 fixed point |

## Verification
Two events can coincide in one cycle: one operation finishes with its `done` pulse, and the next operand is accepted in that same cycle because `busy` has just dropped. The bench provokes this by holding `start` high for a long stretch while the operand changes every cycle. Each accepted operand must then complete exactly 50 edges later, with the value that was present at its own acceptance edge. A per-cycle behavioural model compares `busy`, `done`, `err` and `result` against the design on every cycle. The model also shows that requests made while the unit is busy leave no trace.

// File: rtl/lnq_pkg.sv
package lnq_pkg;

    localparam int MANT_W  = 24;                 // 1.23 mantissa
    localparam int EXP_W   = 8;                  // signed exponent
    localparam int QF      = 24;                 // internal fraction bits / quotient bits
    localparam int RES_IW  = 8;
    localparam int RES_FW  = 20;
    localparam int RES_W   = RES_IW + RES_FW;
    localparam int LN2_FW  = 28;                 // fraction bits of the ln 2 constant
    localparam int DVS_W   = QF + 4;             // divisor width
    localparam int DVD_W   = QF + DVS_W;         // dividend width
    localparam int SUM_W   = LN2_FW + RES_IW + 4;
    localparam int LATENCY = 2 * QF + 2;         // edges from acceptance to done

    localparam int LN2_Q = $rtoi(0.6931471805599453 * (2.0 ** LN2_FW) + 0.5);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV1,
        ST_PREP,
        ST_DIV2,
        ST_FIN
    } lnq_state_e;

    typedef struct packed {
        logic                    bad;
        logic signed [EXP_W-1:0] e;
    } lnq_op_t;

    function automatic logic [RES_W-1:0] lnq_sat_low();
        return {1'b1, {(RES_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/lnq_divider.sv
module lnq_divider
    import lnq_pkg::*;
#(
    parameter int P_DVD_W = DVD_W,
    parameter int P_DVS_W = DVS_W,
    parameter int P_QB    = QF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [P_DVD_W-1:0] dividend,
    input  logic [P_DVS_W-1:0] divisor,
    output logic [P_QB-1:0]    quot,
    output logic               last
);
    localparam int CNT_W = $clog2(P_QB + 1);

    logic [P_DVS_W-1:0] rem_q;
    logic [P_DVS_W-1:0] dvs_q;
    logic [P_QB-1:0]    sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [P_DVS_W:0]   trial;
    logic [P_DVS_W:0]   diff;
    logic               fits;

    always_comb begin
        trial = {rem_q, sh_q[P_QB-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dvs_q <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            // upper part is below the divisor, so only P_QB steps are needed
            rem_q <= dividend[P_QB +: P_DVS_W];
            sh_q  <= dividend[P_QB-1:0];
            dvs_q <= divisor;
            cnt_q <= CNT_W'(P_QB);
        end else if (cnt_q != '0) begin
            rem_q <= fits ? diff[P_DVS_W-1:0] : trial[P_DVS_W-1:0];
            sh_q  <= {sh_q[P_QB-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quot = sh_q;
    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/lnq_pade.sv
module lnq_pade
    import lnq_pkg::*;
(
    input  logic [QF-1:0]    y,
    output logic [DVD_W-1:0] dvd,
    output logic [DVS_W-1:0] dvs
);
    localparam logic [DVS_W-1:0] K15 = DVS_W'(15) << QF;

    logic [2*QF-1:0]  ysq_full;
    logic [QF-1:0]    ysq;
    logic [DVS_W-1:0] num_f;
    logic [DVD_W-1:0] prod;

    always_comb begin
        ysq_full = (2*QF)'(y) * (2*QF)'(y);
        ysq      = ysq_full[2*QF-1:QF];
        num_f    = K15 - (DVS_W'(ysq) << 2);
        dvs      = K15 - DVS_W'(ysq) * DVS_W'(9);
        prod     = DVD_W'(y) * DVD_W'(num_f);
        dvd      = prod << 1;
    end

endmodule

// File: rtl/lnq_unit.sv
module lnq_unit
    import lnq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    in_neg,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic signed [EXP_W-1:0] in_exp,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [RES_W-1:0]        result
);
    localparam int SH = LN2_FW - RES_FW;
    localparam logic signed [SUM_W-1:0] LN2_S = SUM_W'(LN2_Q);
    localparam logic signed [SUM_W-1:0] RND   = SUM_W'(1) <<< (SH - 1);

    lnq_state_e       state_q;
    lnq_op_t          op_q;
    logic             accept;
    logic             div_load;
    logic             div_last;
    logic [QF-1:0]    div_quot;
    logic [DVD_W-1:0] dvd1, dvd2, div_dvd;
    logic [DVS_W-1:0] dvs1, dvs2, div_dvs;
    logic signed [SUM_W-1:0] mant_t, exp_t, sum;
    logic [RES_W-1:0] res_calc;

    assign accept = start && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);

    // first quotient: y = x / (2 + x), with 2.0 expressed in 1.23 units
    always_comb begin
        dvd1 = DVD_W'(in_mant[MANT_W-2:0]) << QF;
        dvs1 = DVS_W'(in_mant[MANT_W-2:0]) + (DVS_W'(1) << MANT_W);
    end

    lnq_pade pade_i (
        .y   (div_quot),
        .dvd (dvd2),
        .dvs (dvs2)
    );

    always_comb begin
        div_load = accept || (state_q == ST_PREP);
        div_dvd  = (state_q == ST_PREP) ? dvd2 : dvd1;
        div_dvs  = (state_q == ST_PREP) ? dvs2 : dvs1;
    end

    lnq_divider #(
        .P_DVD_W (DVD_W),
        .P_DVS_W (DVS_W),
        .P_QB    (QF)
    ) div_i (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quot     (div_quot),
        .last     (div_last)
    );

    // combine mantissa term and exponent term at LN2_FW fraction bits
    always_comb begin
        mant_t   = $signed({{(SUM_W-LN2_FW){1'b0}}, div_quot, {(LN2_FW-QF){1'b0}}});
        exp_t    = $signed({{(SUM_W-EXP_W){op_q.e[EXP_W-1]}}, op_q.e}) * LN2_S;
        sum      = mant_t + exp_t + RND;
        res_calc = sum[SH +: RES_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q.bad <= in_neg || !in_mant[MANT_W-1];
                    op_q.e   <= in_exp;
                    state_q  <= ST_DIV1;
                end
                ST_DIV1: if (div_last) state_q <= ST_PREP;
                ST_PREP: state_q <= ST_DIV2;
                ST_DIV2: if (div_last) state_q <= ST_FIN;
                ST_FIN: begin
                    done    <= 1'b1;
                    err     <= op_q.bad;
                    result  <= op_q.bad ? lnq_sat_low() : res_calc;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lnq_unit_chk.sv
module lnq_unit_chk
    import lnq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [RES_W-1:0] result
);
    logic [7:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= 8'd1;
        else if (lat_cnt != '0) lat_cnt <= lat_cnt + 8'd1;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == 8'(LATENCY + 1)));

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    err_sat_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (result == lnq_sat_low()));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(err)));

endmodule

bind lnq_unit lnq_unit_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .result (result)
);

// File: tb/lnq_unit_tb.sv
`timescale 1ns/1ps
module lnq_unit_tb_top;

    localparam int    LAT = 50;
    localparam real   TOL = 105.0;   // LSBs of 2^-20, about 1e-4

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_neg = 1'b0;
    logic [23:0] in_mant = '0;
    logic signed [7:0] in_exp = '0;
    logic        busy, done, err;
    logic [27:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lnq_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .in_neg(in_neg),
        .in_mant(in_mant), .in_exp(in_exp),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    // behavioural model state
    bit    m_busy = 0, m_done = 0;
    int    m_cnt = 0;
    bit    p_bad, h_bad, h_valid = 0;
    real   p_ref, h_ref;
    string p_tag, h_tag;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic real ref_ln(input logic [23:0] m, input logic signed [7:0] e);
        return $ln(real'(m) / 8388608.0) + real'(int'(e)) * $ln(2.0);
    endfunction

    task automatic compare_all();
        longint act;
        real d;
        act = longint'($signed(result));
        check(busy == m_busy, "R3", "busy", longint'(busy), longint'(m_busy));
        check(done == m_done, "R2", "done", longint'(done), longint'(m_done));
        if (!h_valid) begin
            check(result == '0 && err == 1'b0, "R10", "idle outputs", act, 0);
        end else if (h_bad) begin
            check(err == 1'b1, h_tag, "err", longint'(err), 1);
            check(result == 28'h8000000, h_tag, "saturated result",
                  longint'(result), longint'(28'h8000000));
        end else begin
            check(err == 1'b0, "R10", "err clear", longint'(err), 0);
            d = real'(act) - h_ref * 1048576.0;
            if (d < 0.0) d = -d;
            check(d <= TOL, h_tag, "log value (R6 LSB)", act, longint'($rtoi(h_ref * 1048576.0)));
        end
    endtask

    // one clock: drive now (after a falling edge), model the rising edge, compare
    task automatic cyc(input bit st, input bit ng, input logic [23:0] m,
                       input logic signed [7:0] e);
        bit acc;
        start = st; in_neg = ng; in_mant = m; in_exp = e;
        acc = st && !m_busy;
        @(posedge clk);
        @(negedge clk);
        m_done = 0;
        if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0; m_done = 1;
                h_valid = 1; h_bad = p_bad; h_ref = p_ref; h_tag = p_tag;
            end
        end
        if (acc) begin
            m_busy = 1; m_cnt = LAT;
            p_bad = ng || !m[23];
            p_ref = p_bad ? 0.0 : ref_ln(m, e);
            if (ng) p_tag = "R7";
            else if (!m[23]) p_tag = "R8";
            else if (e == 0) p_tag = "R4";
            else p_tag = "R5";
        end
        compare_all();
    endtask

    task automatic run_op(input bit ng, input logic [23:0] m, input logic signed [7:0] e);
        cyc(1'b1, ng, m, e);
        for (int i = 0; i < LAT + 2; i++) cyc(1'b0, 1'b0, 24'h0, 8'sd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && result == '0, "R1", "reset outputs",
              longint'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        compare_all();   // R1 first cycle after release

        run_op(1'b0, 24'h800000, 8'sd0);
        check(result == '0, "R9", "exact zero", longint'(result), 0);

        run_op(1'b0, 24'hC00000, 8'sd0);   // R4
        run_op(1'b0, 24'hFFFFFF, 8'sd0);
        run_op(1'b0, 24'hA00000, 8'sd0);
        run_op(1'b0, 24'h800001, 8'sd0);
        run_op(1'b0, 24'hB504F3, 8'sd0);

        run_op(1'b0, 24'h800000, 8'sd1);   // R5
        run_op(1'b0, 24'h800000, -8'sd1);
        run_op(1'b0, 24'hFFFFFF, 8'sd127);
        run_op(1'b0, 24'h800000, -8'sd128);
        run_op(1'b0, 24'hD00000, -8'sd5);

        run_op(1'b1, 24'hC00000, 8'sd3);   // R7
        run_op(1'b0, 24'h000000, 8'sd0);   // R8
        run_op(1'b0, 24'h400000, 8'sd2);   // R8
        run_op(1'b0, 24'hC00000, 8'sd2);   // R10 err clears

        // R3: requests during busy are ignored
        cyc(1'b1, 1'b0, 24'hE00000, 8'sd4);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 24'h900000 + 24'(i), -8'sd7);
        for (int i = 0; i < LAT; i++) cyc(1'b0, 1'b0, 24'h0, 8'sd0);

        // completion and acceptance in the same cycle
        for (int i = 0; i < 170; i++)
            cyc(1'b1, 1'b0, 24'h800000 + 24'(i * 24'h0135F1), 8'(i % 9 - 4));
        for (int i = 0; i < LAT + 4; i++) cyc(1'b0, 1'b0, 24'h0, 8'sd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule